// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block connects a simple synchronous request port to a DRAM device that has a shared row/column address bus and active-low strobes. A request holds a 22-bit word address, a 4-bit write value and a direction flag. The controller accepts it only when it shows ready. It then puts the upper half of the address on the 11-pin bus and latches it with the row strobe. Next it puts the lower half on the same pins and latches it with the column strobe. The write-enable or the output-enable strobe is asserted during the column phase to select the direction. Read data comes back with a single-cycle valid pulse.

An internal interval counter raises a refresh request at a fixed period. Each refresh is a row-strobe-only cycle on the row named by an internal row counter. The device restores the whole row during that cycle. The row counter steps through every row and wraps. A pending refresh takes priority over a new request, but it never cuts into an access that is already running. Requests are held off with ready low until the refresh has finished. The data path is split into output, output-enable and input, so that a pad buffer outside the block can form the bidirectional pins.

Top module: `dram_mux_ctrl`

## Requirements
- R1: After reset, all four strobes are high (inactive), the data output enable is low, the read valid flag is low and ready is high.
- R2: For each access, the value on the address bus when the row strobe falls equals address bits [21:11]. The value on the bus when the column strobe falls equals address bits [10:0].
- R3: A write asserts write-enable low and keeps output-enable high during the column strobe. While write-enable is low, the data output enable is high and the data output carries the request's write value. A later read of the same address returns that value.
- R4: A read asserts output-enable low and keeps write-enable high, with the data output enable low. It produces exactly one single-cycle read valid pulse. At that pulse, the read data equals the value last written to that address, or 0 if the address was never written.
- R5: Write-enable and output-enable are never low at the same time. The column strobe is only low while the row strobe is low.
- R6: The row strobe stays low with the column strobe high for exactly T_RCD clocks before the column strobe falls. The column strobe stays low for exactly T_CAS clocks. The row strobe stays high for at least T_PRE clocks between any two row-strobe pulses.
- R7: Ready is low whenever the row strobe or the column strobe is low. Each accepted request produces exactly one column-strobe pulse.
- R8: Refresh cycles pulse the row strobe with the column, write-enable and output-enable strobes held high. The refreshed rows run 0, 1, 2, ... in order, starting at row 0 after reset.
- R9: The refresh row counter wraps from 2047 back to row 0.
- R10: A requester that holds a request asserted without pause cannot starve refresh. Refresh cycles keep occurring at least once per refresh interval plus one access duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in upper half |
| req_wdata | input | 4 | Write value |
| req_ready | output | 1 | Controller idle and no refresh pending |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 4 | Read data, held until the next read |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | 4 | Data towards the device |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | 4 | Data from the device |

## Verification
The bench builds the controller with T_SETUP=2, T_RCD=3, T_CAS=2 and T_PRE=1. With these values the measured strobe widths differ from phase to phase, so a swapped or miscounted phase becomes visible, and the precharge sits at its one-clock minimum. REF_INTERVAL is set to 24 clocks. This lets more than 2048 refresh cycles, and so the 2047-to-0 wrap, occur within a short run. The short interval also makes refresh collide often with a continuously held request.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_RAS,
    PH_CAS,
    PH_PRE
  } phase_e;

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_W        = 11,
  parameter int REF_INTERVAL = 780
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_take,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);
  localparam int IVL   = dram_ctrl_pkg::at_least_one(REF_INTERVAL);
  localparam int CNT_W = (IVL > 1) ? $clog2(IVL) : 1;

  logic [CNT_W-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= CNT_W'(IVL - 1);
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      if (ref_take) begin
        ref_pend <= 1'b0;
        ref_row  <= ref_row + 1'b1;
      end
      if (tick_cnt == '0) begin
        tick_cnt <= CNT_W'(IVL - 1);
        ref_pend <= 1'b1;
      end else begin
        tick_cnt <= tick_cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/dram_strobe_fsm.sv
module dram_strobe_fsm #(
  parameter int ROW_W   = 11,
  parameter int COL_W   = 11,
  parameter int DATA_W  = 4,
  parameter int T_SETUP = 1,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 2,
  parameter int T_PRE   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   req_ready,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  input  logic                   ref_pend,
  input  logic [ROW_W-1:0]       ref_row,
  output logic                   ref_take,
  output logic [ROW_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DATA_W-1:0]      dram_dq_o,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_i
);
  import dram_ctrl_pkg::*;

  localparam int LS    = at_least_one(T_SETUP);
  localparam int LR    = at_least_one(T_RCD);
  localparam int LC    = at_least_one(T_CAS);
  localparam int LP    = at_least_one(T_PRE);
  localparam int LMAX  = (LS > LR ? LS : LR) > (LC > LP ? LC : LP) ?
                         (LS > LR ? LS : LR) : (LC > LP ? LC : LP);
  localparam int CNT_W = (LMAX > 1) ? $clog2(LMAX) : 1;

  phase_e           phase_q, ph_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             is_ref_q, wr_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [DATA_W-1:0] wd_q;

  logic             accept, last;
  logic             ref_nx, wr_nx;
  logic [ROW_W-1:0] row_nx;
  logic [COL_W-1:0] col_nx;
  logic [DATA_W-1:0] wd_nx;
  logic             cas_nx;

  assign req_ready = (phase_q == PH_IDLE) && !ref_pend;
  assign accept    = req_ready && req_valid;
  assign ref_take  = (phase_q == PH_IDLE) && ref_pend;
  assign last      = (cnt_q == '0);

  always_comb begin
    ph_nx  = phase_q;
    cnt_nx = cnt_q;
    unique case (phase_q)
      PH_IDLE:  if (ref_take || accept) begin
                  ph_nx = PH_SETUP; cnt_nx = CNT_W'(LS - 1);
                end
      PH_SETUP: if (last) begin ph_nx = PH_RAS; cnt_nx = CNT_W'(LR - 1); end
                else cnt_nx = cnt_q - 1'b1;
      PH_RAS:   if (last) begin ph_nx = PH_CAS; cnt_nx = CNT_W'(LC - 1); end
                else cnt_nx = cnt_q - 1'b1;
      PH_CAS:   if (last) begin ph_nx = PH_PRE; cnt_nx = CNT_W'(LP - 1); end
                else cnt_nx = cnt_q - 1'b1;
      PH_PRE:   if (last) ph_nx = PH_IDLE;
                else cnt_nx = cnt_q - 1'b1;
      default:  ph_nx = PH_IDLE;
    endcase
  end

  always_comb begin
    ref_nx = is_ref_q;
    wr_nx  = wr_q;
    row_nx = row_q;
    col_nx = col_q;
    wd_nx  = wd_q;
    if (ref_take) begin
      ref_nx = 1'b1;
      wr_nx  = 1'b0;
      row_nx = ref_row;
    end else if (accept) begin
      ref_nx = 1'b0;
      wr_nx  = req_write;
      row_nx = req_addr[ROW_W+COL_W-1:COL_W];
      col_nx = req_addr[COL_W-1:0];
      wd_nx  = req_wdata;
    end
    cas_nx = (ph_nx == PH_CAS) && !ref_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      is_ref_q   <= 1'b0;
      wr_q       <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      wd_q       <= '0;
      dram_addr  <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_oe_n  <= 1'b1;
      dram_dq_o  <= '0;
      dram_dq_oe <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      phase_q    <= ph_nx;
      cnt_q      <= cnt_nx;
      is_ref_q   <= ref_nx;
      wr_q       <= wr_nx;
      row_q      <= row_nx;
      col_q      <= col_nx;
      wd_q       <= wd_nx;
      dram_addr  <= (ph_nx == PH_CAS) ? ROW_W'(col_nx) : row_nx;
      dram_ras_n <= !((ph_nx == PH_RAS) || (ph_nx == PH_CAS));
      dram_cas_n <= !cas_nx;
      dram_we_n  <= !(cas_nx && wr_nx);
      dram_oe_n  <= !(cas_nx && !wr_nx);
      dram_dq_o  <= wd_nx;
      dram_dq_oe <= cas_nx && wr_nx;
      rd_valid   <= 1'b0;
      if ((phase_q == PH_CAS) && last && !is_ref_q && !wr_q) begin
        rd_valid <= 1'b1;
        rd_data  <= dram_dq_i;
      end
    end
  end

endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 11,
  parameter int DATA_W       = 4,
  parameter int T_SETUP      = 1,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_PRE        = 2,
  parameter int REF_INTERVAL = 780
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   req_ready,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  output logic [ROW_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DATA_W-1:0]      dram_dq_o,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_i
);
  logic             ref_pend, ref_take;
  logic [ROW_W-1:0] ref_row;

  dram_refresh_sched #(
    .ROW_W(ROW_W), .REF_INTERVAL(REF_INTERVAL)
  ) u_ref (
    .clk(clk), .rst(rst), .ref_take(ref_take),
    .ref_pend(ref_pend), .ref_row(ref_row)
  );

  dram_strobe_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_SETUP(T_SETUP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_PRE(T_PRE)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_pend(ref_pend), .ref_row(ref_row), .ref_take(ref_take),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_o(dram_dq_o),
    .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
  );

endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
  parameter int T_CAS = 2,
  parameter int T_PRE = 2
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rd_valid,
  input logic dram_ras_n,
  input logic dram_cas_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dram_dq_oe
);
  localparam int LC = (T_CAS < 1) ? 1 : T_CAS;
  localparam int LP = (T_PRE < 1) ? 1 : T_PRE;

  logic [15:0] cas_lo_cnt, ras_hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_lo_cnt <= '0;
      ras_hi_cnt <= 16'hFFFF;
    end else begin
      cas_lo_cnt <= dram_cas_n ? 16'd0 : cas_lo_cnt + 16'd1;
      if (!dram_ras_n)            ras_hi_cnt <= '0;
      else if (ras_hi_cnt != '1)  ras_hi_cnt <= ras_hi_cnt + 16'd1;
    end
  end

  a_r5_we_oe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!dram_we_n && !dram_oe_n));

  a_r5_cas_inside_ras: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);

  a_r3_write_drives: assert property (@(posedge clk) disable iff (rst)
    !dram_we_n |-> dram_dq_oe);

  a_r4_read_released: assert property (@(posedge clk) disable iff (rst)
    !dram_oe_n |-> !dram_dq_oe);

  a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (!dram_ras_n || !dram_cas_n) |-> !req_ready);

  a_r6_cas_width: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_cas_n) |-> (cas_lo_cnt == 16'(LC)));

  a_r6_precharge: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (ras_hi_cnt >= 16'(LP)));

endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(.T_CAS(T_CAS), .T_PRE(T_PRE)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rd_valid(rd_valid),
  .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/tb_dram_mux_ctrl.sv
module tb_dram_mux_ctrl;
  localparam int P_SETUP = 2;
  localparam int P_RCD   = 3;
  localparam int P_CAS   = 2;
  localparam int P_PRE   = 1;
  localparam int P_IVL   = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [3:0]  rd_data;
  logic [10:0] dram_addr;
  logic        ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [3:0]  dq_o, dq_i;

  always #2 clk = ~clk;

  dram_mux_ctrl #(
    .T_SETUP(P_SETUP), .T_RCD(P_RCD), .T_CAS(P_CAS), .T_PRE(P_PRE),
    .REF_INTERVAL(P_IVL)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
    .dram_oe_n(oe_n), .dram_dq_o(dq_o), .dram_dq_oe(dq_oe),
    .dram_dq_i(dq_i)
  );

  // behavioural device model and strobe monitor, sampled mid-cycle
  logic [3:0]  mem [int];
  logic [3:0]  rdq = '0;
  logic [10:0] mrow = '0, acc_row = '0, acc_col = '0;
  logic [10:0] exp_ref = '0, last_ref = '0;
  logic        prev_ras = 1'b1, prev_cas = 1'b1, cas_seen = 1'b0;
  logic        wrap_seen = 1'b0;
  int rcd_run = 0, rcd_meas = 0, cas_run = 0, cas_meas = 0;
  int ref_count = 0, ref_seq_err = 0, excl_err = 0, busy_err = 0;
  int rdv_count = 0, cas_count = 0, accept_count = 0;

  assign dq_i = (!oe_n && !cas_n) ? rdq : 4'h0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_ras && !ras_n) begin mrow = dram_addr; rcd_run = 0; cas_seen = 1'b0; end
      if (!ras_n && cas_n && !cas_seen) rcd_run++;
      if (prev_cas && !cas_n) begin
        cas_seen = 1'b1; rcd_meas = rcd_run; cas_run = 0; cas_count++;
        acc_row = mrow; acc_col = dram_addr;
        rdq = mem.exists(int'({mrow, dram_addr})) ? mem[int'({mrow, dram_addr})] : 4'h0;
        if (!we_n) mem[int'({mrow, dram_addr})] = dq_o;
      end
      if (!cas_n) cas_run++;
      if (!prev_cas && cas_n) cas_meas = cas_run;
      if (!prev_ras && ras_n && !cas_seen) begin
        ref_count++;
        if (mrow != exp_ref || !we_n || !oe_n) ref_seq_err++;
        if (ref_count > 1 && last_ref == 11'd2047 && mrow == 11'd0) wrap_seen = 1'b1;
        last_ref = mrow;
        exp_ref  = exp_ref + 11'd1;
      end
      if (!we_n && !oe_n) excl_err++;
      if ((!ras_n || !cas_n) && req_ready) busy_err++;
      if (rd_valid) rdv_count++;
      if (req_valid && req_ready) accept_count++;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_access(input bit wr, input logic [21:0] a,
                           input logic [3:0] d, output logic [3:0] q);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    q = rd_data;
  endtask

  typedef struct packed {
    logic        wr;
    logic [21:0] a;
    logic [3:0]  d;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 22'h000000, 4'hA}, '{1'b1, 22'h3FFFFF, 4'h5},
    '{1'b1, 22'h2AAAAA, 4'h3}, '{1'b1, 22'h0007FF, 4'hC},
    '{1'b1, 22'h3FF800, 4'h6}, '{1'b0, 22'h000000, 4'hA},
    '{1'b0, 22'h3FFFFF, 4'h5}, '{1'b0, 22'h2AAAAA, 4'h3},
    '{1'b0, 22'h0007FF, 4'hC}, '{1'b0, 22'h3FF800, 4'h6},
    '{1'b1, 22'h000000, 4'hF}, '{1'b0, 22'h000000, 4'hF},
    '{1'b0, 22'h123456, 4'h0}
  };

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc == 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [3:0] q;
    int rdv0, cas0, ref0, acc0, guard;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n && oe_n && !dq_oe && !rd_valid && req_ready,
        "R1 reset outputs", {ras_n, cas_n, we_n, oe_n, dq_oe, rd_valid, req_ready}, 7'b1111001);

    for (int i = 0; i < NV; i++) begin
      rdv0 = rdv_count; cas0 = cas_count;
      do_access(VEC[i].wr, VEC[i].a, VEC[i].d, q);
      chk(acc_row == VEC[i].a[21:11], "R2 row half", int'(acc_row), int'(VEC[i].a[21:11]));
      chk(acc_col == VEC[i].a[10:0], "R2 column half", int'(acc_col), int'(VEC[i].a[10:0]));
      chk(cas_count - cas0 == 1, "R7 one column pulse", cas_count - cas0, 1);
      chk(rcd_meas == P_RCD, "R6 row-to-column delay", rcd_meas, P_RCD);
      chk(cas_meas == P_CAS, "R6 column pulse width", cas_meas, P_CAS);
      if (!VEC[i].wr) begin
        chk(rdv_count - rdv0 == 1, "R4 one valid pulse", rdv_count - rdv0, 1);
        chk(q == VEC[i].d, "R3 R4 read data", int'(q), int'(VEC[i].d));
      end else begin
        chk(rdv_count == rdv0, "R3 no valid on write", rdv_count - rdv0, 0);
      end
    end

    // R10: request held without pause; refresh must still happen
    ref0 = ref_count; acc0 = accept_count;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 22'h155555;
    repeat (300) @(negedge clk);
    req_valid = 1'b0;
    chk(ref_count - ref0 >= 300 / (P_IVL + 12), "R10 refresh under load",
        ref_count - ref0, 300 / (P_IVL + 12));
    chk(accept_count - acc0 >= 10, "R10 requests still served", accept_count - acc0, 10);

    // R9: run past one full sweep of rows
    guard = 0;
    while (ref_count < 2052 && guard < 120000) begin @(negedge clk); guard++; end
    chk(ref_count >= 2052, "R9 refresh count", ref_count, 2052);
    chk(wrap_seen, "R9 row wrap 2047->0", int'(wrap_seen), 1);
    chk(ref_seq_err == 0, "R8 refresh row order", ref_seq_err, 0);
    chk(excl_err == 0, "R5 WE/OE exclusive", excl_err, 0);
    chk(busy_err == 0, "R7 ready low while busy", busy_err, 0);

    // R3: data written before the long refresh run still reads back
    do_access(1'b0, 22'h2AAAAA, 4'h0, q);
    chk(q == 4'h3, "R3 data kept across refresh", int'(q), 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule